// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital controller of an integrating analog-to-digital converter. It sequences an external integrator, a two-way input switch and a zero-crossing comparator. It does not process any samples itself. A conversion has three steps. First, the integrator is clamped to zero. Then the analog input is integrated for a fixed number of clock cycles. Finally, the switch selects the negative reference, and the sequencer counts cycles until the comparator reports that the integrator has returned to zero.

The count from the last step is the conversion result. It equals the input scaled by the fixed run-up length over the reference, and it does not depend on the integrator's resistor and capacitor. A single internal counter serves all three steps and is cleared between them. If the rundown count reaches all ones and the comparator is still high, the block stops, reports all ones and raises an over-range flag. Each completed conversion is marked by a one-cycle done pulse.

Top module: `dual_slope_seq`

## Requirements
- R1: After synchronous reset the block is idle: `sel_ref`, `int_rst`, `cnt_gate`, `done` and `over_range` are 0, and `result` is 0.
- R2: A `start` sampled high while idle makes `int_rst` high for exactly RST_CYC consecutive cycles, beginning in the cycle after the sampling edge. During those cycles `cnt_gate` is 0 and `sel_ref` is 0.
- R3: For the N_INT cycles that follow the clamp, `sel_ref` is 0 (input selected), `cnt_gate` is 1 and `int_rst` is 0.
- R4: After run-up, `sel_ref` is 1 (reference selected) and `cnt_gate` follows `cmp_hi`. The rundown ends in the first cycle in which `cmp_hi` is 0. The result is the number of rundown cycles before that cycle, all of which had `cmp_hi` high.
- R5: `done` is high for exactly one cycle, the cycle after the rundown ends. `result` and `over_range` take their new values in that same cycle, and the block is idle in the next cycle.
- R6: If `cmp_hi` is still high in the rundown cycle in which the count has reached 2^CNT_W-1, the block stops, `result` becomes all ones and `over_range` is 1. A rundown that ends with a count of exactly 2^CNT_W-1 gives that value with `over_range` 0.
- R7: `start` is ignored while a conversion is in progress: a conversion is never restarted or shortened by it.
- R8: Between done pulses, `result` and `over_range` hold their values.
- R9: With a linear integrator that gains Vin per run-up cycle and loses Vref per rundown cycle, the result is ceil(N_INT·Vin/Vref), clipped to all ones as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, sampled while idle |
| cmp_hi | input | 1 | Comparator: 1 while integrator output is above zero |
| sel_ref | output | 1 | Switch select: 0 analog input, 1 negative reference |
| int_rst | output | 1 | Integrator clamp to zero |
| cnt_gate | output | 1 | Count gate, open while counting |
| done | output | 1 | One-cycle pulse when a new result is presented |
| over_range | output | 1 | Last conversion overflowed the count |
| result | output | CNT_W | Latched rundown count |

## Verification
The bench builds the block with CNT_W=6, N_INT=20 and RST_CYC=3. With these values, full scale is only 63 counts, so a conversion lasts well under a hundred cycles. The rundown can therefore be driven to exactly 63 and to one count past it, which covers both sides of the over-range boundary in R6. Reference values of 20, 10, 7 and 1 give exact and rounded-up ratios, and a zero input gives an empty rundown.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLAMP,
        ST_RUNUP,
        ST_RUNDOWN,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        CNT_HOLD,
        CNT_CLEAR,
        CNT_STEP
    } cnt_op_e;

    typedef struct packed {
        logic sel_ref;
        logic int_rst;
        logic gate;
    } drive_t;

    function automatic drive_t drive_of(seq_state_e st, logic cmp);
        drive_t d;
        d = '0;
        case (st)
            ST_CLAMP:   d.int_rst = 1'b1;
            ST_RUNUP:   d.gate    = 1'b1;
            ST_RUNDOWN: begin
                d.sel_ref = 1'b1;
                d.gate    = cmp;
            end
            default:    d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dsadc_counter.sv
module dsadc_counter
    import dsadc_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_op_e          op,
    output logic [CNT_W-1:0] value
);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else begin
            case (op)
                CNT_CLEAR: value <= '0;
                CNT_STEP:  value <= value + 1'b1;
                default:   value <= value;
            endcase
        end
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (op == CNT_STEP) |-> (value != {CNT_W{1'b1}})); // R6

endmodule

// File: rtl/dsadc_fsm.sv
module dsadc_fsm
    import dsadc_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int N_INT   = 1000,
    parameter int RST_CYC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cmp_hi,
    input  logic [CNT_W-1:0] count,
    output seq_state_e       state,
    output cnt_op_e          op,
    output logic             load,
    output logic             ovr
);

    localparam logic [CNT_W-1:0] CLAMP_LAST = CNT_W'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] RUNUP_LAST = CNT_W'(N_INT - 1);
    localparam logic [CNT_W-1:0] FULL_SCALE = {CNT_W{1'b1}};

    seq_state_e nxt;

    always_comb begin
        nxt  = state;
        op   = CNT_HOLD;
        load = 1'b0;
        ovr  = 1'b0;
        case (state)
            ST_IDLE: begin
                op = CNT_CLEAR;
                if (start) nxt = ST_CLAMP;
            end
            ST_CLAMP: begin
                if (count == CLAMP_LAST) begin
                    op  = CNT_CLEAR;
                    nxt = ST_RUNUP;
                end else begin
                    op = CNT_STEP;
                end
            end
            ST_RUNUP: begin
                if (count == RUNUP_LAST) begin
                    op  = CNT_CLEAR;
                    nxt = ST_RUNDOWN;
                end else begin
                    op = CNT_STEP;
                end
            end
            ST_RUNDOWN: begin
                if (!cmp_hi) begin
                    nxt  = ST_DONE;
                    load = 1'b1;
                end else if (count == FULL_SCALE) begin
                    nxt  = ST_DONE;
                    load = 1'b1;
                    ovr  = 1'b1;
                end else begin
                    op = CNT_STEP;
                end
            end
            ST_DONE: begin
                op  = CNT_CLEAR;
                nxt = ST_IDLE;
            end
            default: begin
                op  = CNT_CLEAR;
                nxt = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUNUP && start) |=> (state != ST_CLAMP)); // R7

    AST_RUNDOWN_END: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUNDOWN && !cmp_hi) |=> (state == ST_DONE)); // R4

endmodule

// File: rtl/dsadc_latch.sv
module dsadc_latch #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             ovr,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] result,
    output logic             over_range
);

    always_ff @(posedge clk) begin
        if (rst) begin
            result     <= '0;
            over_range <= 1'b0;
        end else if (load) begin
            result     <= ovr ? {CNT_W{1'b1}} : count;
            over_range <= ovr;
        end
    end

    AST_OVR_ONES: assert property (@(posedge clk) disable iff (rst)
        over_range |-> (result == {CNT_W{1'b1}})); // R6

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
    import dsadc_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int N_INT   = 1000,
    parameter int RST_CYC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cmp_hi,
    output logic             sel_ref,
    output logic             int_rst,
    output logic             cnt_gate,
    output logic             done,
    output logic             over_range,
    output logic [CNT_W-1:0] result
);

    seq_state_e       state;
    cnt_op_e          op;
    logic             load;
    logic             ovr;
    logic [CNT_W-1:0] count;
    drive_t           drv;

    dsadc_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .value (count)
    );

    dsadc_fsm #(.CNT_W(CNT_W), .N_INT(N_INT), .RST_CYC(RST_CYC)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .cmp_hi (cmp_hi),
        .count  (count),
        .state  (state),
        .op     (op),
        .load   (load),
        .ovr    (ovr)
    );

    dsadc_latch #(.CNT_W(CNT_W)) u_latch (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .ovr        (ovr),
        .count      (count),
        .result     (result),
        .over_range (over_range)
    );

    assign drv      = drive_of(state, cmp_hi);
    assign sel_ref  = drv.sel_ref;
    assign int_rst  = drv.int_rst;
    assign cnt_gate = drv.gate;
    assign done     = (state == ST_DONE);

    AST_CLAMP_NO_GATE: assert property (@(posedge clk) disable iff (rst)
        int_rst |-> (!cnt_gate && !sel_ref)); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result) && $stable(over_range))); // R8

endmodule

// File: tb/test_dual_slope_seq.sv
module test_dual_slope_seq;

    localparam int CLK_PERIOD = 10;
    localparam int W    = 6;
    localparam int NI   = 20;
    localparam int RC   = 3;
    localparam int FULL = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         cmp_hi;
    logic         sel_ref, int_rst, cnt_gate, done, over_range;
    logic [W-1:0] result;

    integer acc  = 0;
    integer vin  = 0;
    integer vref = 1;
    integer errors = 0;
    integer checks = 0;

    dual_slope_seq #(.CNT_W(W), .N_INT(NI), .RST_CYC(RC)) i_dual_slope_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cmp_hi     (cmp_hi),
        .sel_ref    (sel_ref),
        .int_rst    (int_rst),
        .cnt_gate   (cnt_gate),
        .done       (done),
        .over_range (over_range),
        .result     (result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural integrator and zero-crossing comparator
    assign cmp_hi = (acc > 0);
    always @(posedge clk) begin
        if (int_rst)       acc <= 0;
        else if (cnt_gate) acc <= sel_ref ? acc - vref : acc + vin;
    end

    task automatic check(input string req, input integer act, input integer exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_conv(input integer vi, input integer vr, input bit poke);
        integer t, exp_res, dcyc;
        bit ovf;
        vin  = vi;
        vref = vr;
        t    = (NI * vi + vr - 1) / vr;
        ovf  = (t > FULL);
        exp_res = ovf ? FULL : t;
        dcyc = ovf ? FULL + 1 : t + 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < RC; i++) begin
            check("R2 int_rst", int_rst, 1);
            check("R2 gate", cnt_gate, 0);
            check("R2 sel_ref", sel_ref, 0);
            @(negedge clk);
        end
        for (int i = 0; i < NI; i++) begin
            check("R3 sel_ref", sel_ref, 0);
            check("R3 gate", cnt_gate, 1);
            check("R3 int_rst", int_rst, 0);
            check("R7 no done", done, 0);
            start = (poke && (i == 5 || i == 6));
            @(negedge clk);
        end
        start = 1'b0;
        for (int k = 0; k < dcyc; k++) begin
            check("R4 sel_ref", sel_ref, 1);
            check("R4 gate", cnt_gate, (ovf || k < t) ? 1 : 0);
            check("R5 no early done", done, 0);
            @(negedge clk);
        end
        check("R5 done", done, 1);
        check("R9 result", result, exp_res);
        check("R6 over_range", over_range, ovf ? 1 : 0);
        @(negedge clk);
        check("R5 done drops", done, 0);
        check("R5 idle sel_ref", sel_ref, 0);
        check("R5 idle int_rst", int_rst, 0);
        for (int i = 0; i < 3; i++) begin
            check("R8 result hold", result, exp_res);
            check("R8 over hold", over_range, ovf ? 1 : 0);
            check("R8 gate idle", cnt_gate, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors = errors + 1;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 sel_ref", sel_ref, 0);
        check("R1 int_rst", int_rst, 0);
        check("R1 gate", cnt_gate, 0);
        check("R1 done", done, 0);
        check("R1 over", over_range, 0);
        check("R1 result", result, 0);

        run_conv(5, 7, 1'b0);   // R9 rounded up: 100/7 -> 15
        run_conv(0, 5, 1'b0);   // R4 empty rundown -> 0
        run_conv(63, 20, 1'b0); // R6 exact full scale, no flag
        run_conv(64, 20, 1'b0); // R6 one past full scale
        run_conv(10, 10, 1'b1); // R7 start during run-up, result 20
        run_conv(3, 1, 1'b0);   // R9 exact ratio 60, flag cleared
        run_conv(1, 20, 1'b0);  // R9 single count

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule